// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 45-bit physical address by walking a three-level radix page table in memory. A translation request carries the virtual address and the page number of the level-1 table, which serves as the base register for the walk. The walker first checks that the upper 21 address bits are clear. It then issues one 8-byte table-entry read per level over a memory read port. Each entry it reads supplies the page number of the next table. The walk ends with a one-cycle completion pulse that carries either the physical address or a fault and the level at which the walk stopped.

The virtual address splits into four fields. The level-1 index is bits [42:33], the level-2 index is bits [32:23], the level-3 index is bits [22:13], and the page offset is bits [12:0]. Bits [63:43] must be zero. A table entry holds a valid flag in bit 0 and a 32-bit page number in bits [63:32]. Table pages are 8 KB, so each one holds 1024 entries.

The walker is a four-state machine. The states are IDLE, ISSUE, WAIT and DONE.
- IDLE goes to ISSUE when it accepts a request, or straight to DONE if the upper bits are nonzero.
- ISSUE goes to WAIT when the memory accepts the read.
- WAIT goes back to ISSUE for the next level when a valid entry returns. It goes to DONE when an entry comes back invalid or the level-3 entry has arrived.
- DONE returns to IDLE after one cycle.

Top module: `pt_walker`

## Requirements
- R1: The 13-bit page offset, virtual address bits [12:0], appears unchanged in physical address bits [12:0].
- R2: If any of virtual address bits [63:43] is set, the walk completes with a fault at level 0 (`done_level`=0), and no memory read is issued.
- R3: The read address at each level is the current table page number shifted left by 13, plus the level's 10-bit index shifted left by 3. The level-1 read uses `base_ppn`; each later level uses the page number from the previous entry, taken from entry bits [63:32].
- R4: A successful walk issues exactly three reads, for levels 1, 2 and 3 in that order.
- R5: A table entry whose bit 0 is clear ends the walk at once. The walk reports a fault with `done_level` equal to the failing level (1, 2 or 3) and a physical address of zero, and it issues no further reads.
- R6: On success, the physical address is the level-3 entry's page number (bits [63:32]) concatenated above the 13-bit page offset, and `done_fault` is 0.
- R7: `req_ready` is high only in IDLE. A request presented while a walk is in progress is ignored and does not change the walk's result.
- R8: `done` is a pulse exactly one cycle long, and `req_ready` is high again in the following cycle.
- R9: At most one read is outstanding. A read request that has not been accepted keeps `mem_req_valid` high and holds its address stable.
- R10: After reset, `req_ready` is 1, and `mem_req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address to translate |
| base_ppn | input | 32 | Page number of the level-1 table (base register) |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 45 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry: bit 0 valid, bits [63:32] page number |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_level | output | 2 | Fault level: 0 for nonzero upper bits, 1 to 3 for an invalid entry |
| done_pa | output | 45 | Physical address, zero on a fault |

## Verification
Assertions check several protocol properties on every cycle:
- `done` is a single-cycle pulse.
- `req_ready` drops after a request is accepted.
- A pending read stays stable until it is accepted.
- No second read is issued while one is outstanding.
- A request with nonzero upper bits faults at level 0 with no read.

The bench's scenarios show the properties that depend on data: the exact sequence of entry addresses, the composed physical address, the fault level when an invalid entry sits at each level, and the fact that requests made during a walk are ignored. It compares each of these against a reference walk computed from the same model of memory contents.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_BITS   = 64;
    localparam int OFF_BITS  = 13;
    localparam int IDX_BITS  = 10;
    localparam int NUM_LVL   = 3;
    localparam int PPN_BITS  = 32;
    localparam int PTE_BITS  = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
    parameter int VA_W   = 64,
    parameter int OFF_W  = 13,
    parameter int IDX_W  = 10,
    parameter int LEVELS = 3
) (
    input  logic [VA_W-1:0]              va,
    output logic [LEVELS-1:0][IDX_W-1:0] idx,
    output logic [OFF_W-1:0]             offset,
    output logic                         upper_bad
);
    localparam int USED_W = OFF_W + LEVELS * IDX_W;

    assign offset    = va[OFF_W-1:0];
    assign upper_bad = |va[VA_W-1:USED_W];

    // idx[0] is the level-1 index, taken from the most significant used field
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
    end
endmodule

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr #(
    parameter int PPN_W   = 32,
    parameter int OFF_W   = 13,
    parameter int IDX_W   = 10,
    parameter int ENTRY_B = 8
) (
    input  logic [PPN_W-1:0]       table_ppn,
    input  logic [IDX_W-1:0]       index,
    output logic [PPN_W+OFF_W-1:0] addr
);
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int SCALE_SH = $clog2(ENTRY_B);

    logic [PA_W-1:0] table_base;
    logic [PA_W-1:0] scaled_idx;

    assign table_base = {table_ppn, {OFF_W{1'b0}}};
    assign scaled_idx = PA_W'({index, {SCALE_SH{1'b0}}});
    assign addr       = table_base + scaled_idx;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = VA_BITS,
    parameter int OFF_W  = OFF_BITS,
    parameter int IDX_W  = IDX_BITS,
    parameter int LEVELS = NUM_LVL,
    parameter int PPN_W  = PPN_BITS,
    parameter int PTE_W  = PTE_BITS,
    parameter int PA_W   = PPN_W + OFF_W,
    parameter int LVL_W  = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PPN_W-1:0]  base_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              done_fault,
    output logic [LVL_W-1:0]  done_level,
    output logic [PA_W-1:0]   done_pa
);
    localparam int ENTRY_BYTES = PTE_W / 8;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS);
    localparam logic [LVL_W-1:0] ONE_LVL  = LVL_W'(1);

    walk_state_e state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] ppn_q;
    logic [LVL_W-1:0] lvl_q;
    logic             fault_q;
    logic [LVL_W-1:0] flvl_q;

    logic [LEVELS-1:0][IDX_W-1:0] q_idx;
    logic [OFF_W-1:0]             q_off;
    logic                         q_upper_bad;
    logic [LEVELS-1:0][IDX_W-1:0] in_idx;
    logic [OFF_W-1:0]             in_off;
    logic                         in_upper_bad;
    logic [LVL_W-1:0]             lvl_sel;
    logic [PA_W-1:0]              pte_addr;
    logic                         accept;
    logic                         rsp_ok;

    ptw_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_split_q (
        .va(va_q), .idx(q_idx), .offset(q_off), .upper_bad(q_upper_bad)
    );

    ptw_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_split_in (
        .va(req_va), .idx(in_idx), .offset(in_off), .upper_bad(in_upper_bad)
    );

    assign lvl_sel = lvl_q - ONE_LVL;

    ptw_pte_addr #(.PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_B(ENTRY_BYTES)) u_addr (
        .table_ppn(ppn_q), .index(q_idx[lvl_sel]), .addr(pte_addr)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign rsp_ok = mem_rsp_data[0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = in_upper_bad ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) begin
                          if (!rsp_ok || lvl_q == LAST_LVL) state_d = ST_DONE;
                          else                              state_d = ST_ISSUE;
                      end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            ppn_q   <= '0;
            lvl_q   <= '0;
            fault_q <= 1'b0;
            flvl_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    va_q    <= req_va;
                    ppn_q   <= base_ppn;
                    lvl_q   <= ONE_LVL;
                    fault_q <= in_upper_bad;
                    flvl_q  <= '0;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!rsp_ok) begin
                        fault_q <= 1'b1;
                        flvl_q  <= lvl_q;
                    end else begin
                        ppn_q <= mem_rsp_data[PTE_W-1 -: PPN_W];
                        if (lvl_q != LAST_LVL) lvl_q <= lvl_q + ONE_LVL;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = pte_addr;
        done          = (state_q == ST_DONE);
        done_fault    = fault_q;
        done_level    = fault_q ? flvl_q : '0;
        done_pa       = fault_q ? '0 : {ppn_q, q_off};
    end

    // ------------------------------------------------------------------
    // assertions
    logic rd_open_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                              rd_open_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) rd_open_q <= 1'b1;
        else if (mem_rsp_valid)                  rd_open_q <= 1'b0;
    end

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rd_open_q);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_upper_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && in_upper_bad) |=>
            (done && done_fault && done_level == '0 && !mem_req_valid));

    assert_split_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_pa[OFF_W-1:0] == q_off && !q_upper_bad));
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [31:0] base_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [44:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        done_fault;
    logic [1:0]  done_level;
    logic [44:0] done_pa;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    int          kill_lvl = 0;
    int          rd_cnt = 0;
    logic [44:0] rd_addr [1:4];
    bit          pend = 0;
    logic [63:0] pend_data;

    logic [44:0] exp_addr [1:3];

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .base_ppn(base_ppn), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_level(done_level), .done_pa(done_pa)
    );

    function automatic logic [31:0] ppn_of(input logic [44:0] a);
        logic [31:0] h;
        h = a[31:0] * 32'h9E37_79B1;
        return h ^ {a[44:13], 3'b0}[31:0] ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: entry at the killed level has bit 0 clear
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pend_data;
                pend = 0;
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready && !pend) begin
                rd_cnt++;
                if (rd_cnt <= 4) rd_addr[rd_cnt] = mem_req_addr;
                pend_data = {ppn_of(mem_req_addr), 31'h0, (rd_cnt != kill_lvl)};
                pend = 1;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic run_walk(input logic [63:0] va, input logic [31:0] base, input int kill, input bit poke);
        bit          e_fault;
        int          e_lvl;
        int          e_reads;
        logic [44:0] e_pa;
        logic [31:0] p;
        int          n;
        // reference walk
        e_fault = 0; e_lvl = 0; e_reads = 0; e_pa = '0;
        if (va[63:43] != 0) begin
            e_fault = 1;
        end else begin
            p = base;
            for (int l = 1; l <= 3; l++) begin
                logic [9:0] ix;
                ix = va[13 + (3-l)*10 +: 10];
                exp_addr[l] = {p, 13'h0} + {32'h0, ix, 3'b0};
                e_reads = l;
                if (l == kill) begin e_fault = 1; e_lvl = l; break; end
                p = ppn_of(exp_addr[l]);
            end
            if (!e_fault) e_pa = {p, va[12:0]};
        end
        kill_lvl = kill;
        rd_cnt = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 idle ready", {63'h0, req_ready}, 64'h1);
        req_valid = 1'b1; req_va = va; base_ppn = base;
        @(negedge clk);
        if (poke) begin req_va = ~va & 64'h0000_07FF_FFFF_FFFF; base_ppn = ~base; end
        else req_valid = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            if (poke) chk(req_ready == 1'b0, "R7 busy ready low", {63'h0, req_ready}, 64'h0);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R8 done seen", {63'h0, done}, 64'h1);
        chk(done_fault == e_fault, e_fault && e_lvl == 0 ? "R2 fault flag" : "R5 fault flag",
            {63'h0, done_fault}, {63'h0, e_fault});
        chk(done_level == 2'(e_lvl), "R5 fault level", {62'h0, done_level}, 64'(e_lvl));
        chk(done_pa == e_pa, "R6 physical address", {19'h0, done_pa}, {19'h0, e_pa});
        if (!e_fault) chk(done_pa[12:0] == va[12:0], "R1 offset", {51'h0, done_pa[12:0]}, {51'h0, va[12:0]});
        chk(rd_cnt == e_reads, e_reads == 0 ? "R2 no reads" : "R4 read count", 64'(rd_cnt), 64'(e_reads));
        for (int l = 1; l <= 3; l++)
            if (l <= e_reads && l <= rd_cnt)
                chk(rd_addr[l] == exp_addr[l], "R3 entry address", {19'h0, rd_addr[l]}, {19'h0, exp_addr[l]});
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R8 single pulse", {62'h0, done, req_ready}, 64'h1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0, "R10 reset outputs",
            {61'h0, req_ready, mem_req_valid, done}, 64'h4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0, "R10 after reset",
            {61'h0, req_ready, mem_req_valid, done}, 64'h4);

        // directed corners
        run_walk(64'h0000_0000_0000_0000, 32'h0000_0000, 0, 0);
        run_walk(64'h0000_07FF_FFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        run_walk(64'h8000_0000_0000_0000, 32'h1234_5678, 0, 0);   // R2 top bit
        run_walk(64'h0000_0800_0000_0000, 32'h1234_5678, 0, 0);   // R2 lowest upper bit
        run_walk(64'h0000_0123_4567_89AB, 32'h0000_1000, 1, 0);   // R5 level 1
        run_walk(64'h0000_0123_4567_89AB, 32'h0000_1000, 2, 0);   // R5 level 2
        run_walk(64'h0000_0123_4567_89AB, 32'h0000_1000, 3, 0);   // R5 level 3
        run_walk(64'h0000_0555_AAAA_5555, 32'hCAFE_0001, 0, 1);   // R7 request while busy

        // constrained random
        for (int i = 0; i < 120; i++) begin
            logic [63:0] va;
            int k;
            va = {$urandom, $urandom};
            if (($urandom % 8) != 0) va[63:43] = '0;
            k = $urandom % 6;
            if (k > 3) k = 0;
            run_walk(va, $urandom, k, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule